// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Transmit Lock

This block gathers six single-cycle event pulses from a serial link controller into pending latches, filters them through a host-writable mask, and raises one registered interrupt line whenever any unmasked pending event exists. A host uses a small register bus to read the status byte or to read and write the mask byte. Reading status reports only the unmasked pending events and clears exactly those. Masked events are not lost: they stay latched and surface in status once their mask bit is cleared.

Two transmit-side events, message repeat and data underrun, also drive a transmitter lock output. The lock follows the internal pending latches of those two sources, so it stays high while either is pending, even if it is masked. It drops only after the host reads status with that source unmasked.

Byte layout, shared by status and mask: bit 7 receive message end (event input 5), bit 6 receive pool full (input 4), bit 5 receive overflow (input 3), bit 4 transmit pool ready (input 2), bit 3 transmit repeat (input 1), bit 2 transmit underrun (input 0). Bits 1..0 read as zero. Register address 0 is status and address 1 is mask.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every mask bit is 1, every pending latch is 0, a status read returns 0x00, a mask read returns 0xFC, and irqOut and txLock are 0.
- R2: A status read (hostSel=1, hostWr=0, hostAddr=0) returns in bits 7..2 the pending AND not-masked sources, with event input k at bit k+2. Bits 1..0 are 0.
- R3: A mask write (hostSel=1, hostWr=1, hostAddr=1) loads bits 7..2 of hostWdata, with 1 meaning masked. A mask read returns those bits with bits 1..0 at 0.
- R4: An event on a masked source is latched without appearing in status. It appears in status once its mask bit is written 0.
- R5: A status read clears, at the end of the read cycle, exactly the bits it reported. Masked pending bits are left untouched.
- R6: An event arriving in the same cycle as a status read that would clear its bit leaves that bit set.
- R7: irqOut is high one clock after any visible (unmasked) pending bit exists, and low one clock after none does.
- R8: txLock is high from the clock after an underrun (input 0) or repeat (input 1) event. It stays high, whatever the mask, until a status read that reports that source clears its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 6 | Single-cycle event pulses, one per source |
| hostSel | input | 1 | Register access in this cycle |
| hostWr | input | 1 | 1 write, 0 read |
| hostAddr | input | 1 | 0 status, 1 mask |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data (combinational) |
| irqOut | output | 1 | Registered combined interrupt |
| txLock | output | 1 | Transmitter lock |

## Verification
The assertions assume that each event input is a single-cycle pulse, and that a host access occupies exactly one cycle with its control and data stable across that cycle. The bench drives every input on the falling clock edge, keeps each access and each pulse to one cycle, and never writes status. The lock and clear properties therefore only see reads and mask writes. Events that collide with clearing reads are applied deliberately, in one cycle each, so that the pulse-versus-clear priority is exercised within those limits.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  typedef struct packed {
    logic rdStatus;
    logic wrMask;
    logic selMask;
  } hostStrobeT;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostAddr,
  output hostStrobeT strobe
);
  // address 0: status (read clears visible bits), address 1: mask
  always_comb begin
    strobe.rdStatus = hostSel && !hostWr && !hostAddr;
    strobe.wrMask   = hostSel &&  hostWr &&  hostAddr;
    strobe.selMask  = hostAddr;
  end
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8,
  parameter logic [NUM_SRC-1:0] LOCK_SRC = 6'b000011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  hostStrobeT         strobe,
  input  logic [NUM_SRC-1:0] maskWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               irqOut,
  output logic               txLock
);
  localparam int PAD = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] visible;

  assign visible = pendQ & ~maskQ;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    // new pulse has priority over a clearing read
    always_ff @(posedge clk) begin
      if (!rstN)                                pendQ[k] <= 1'b0;
      else if (evtPulse[k])                     pendQ[k] <= 1'b1;
      else if (strobe.rdStatus && !maskQ[k])    pendQ[k] <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)              maskQ[k] <= 1'b1;
      else if (strobe.wrMask) maskQ[k] <= maskWdata[k];
    end
  end

  always_comb begin
    hostRdata = '0;
    hostRdata[DATA_W-1:PAD] = strobe.selMask ? maskQ : visible;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |visible;
  end

  assign txLock = |(pendQ & LOCK_SRC);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic               hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               irqOut,
  output logic               txLock
);
  localparam int PAD = DATA_W - NUM_SRC;

  hostStrobeT strobe;
  logic unusedPad;
  assign unusedPad = ^hostWdata[PAD-1:0];

  irq_status_ctrl ctrl_i (
    .hostSel (hostSel),
    .hostWr  (hostWr),
    .hostAddr(hostAddr),
    .strobe  (strobe)
  );

  irq_status_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtPulse (evtPulse),
    .strobe   (strobe),
    .maskWdata(hostWdata[DATA_W-1:PAD]),
    .hostRdata(hostRdata),
    .irqOut   (irqOut),
    .txLock   (txLock)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8,
  parameter logic [NUM_SRC-1:0] LOCK_SRC = 6'b000011
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               hostSel,
  input logic               hostWr,
  input logic               hostAddr,
  input logic [DATA_W-1:0]  hostWdata,
  input logic [DATA_W-1:0]  hostRdata,
  input logic               irqOut,
  input logic               txLock,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] mask
);
  localparam int PAD = DATA_W - NUM_SRC;
  logic statusRead;
  assign statusRead = hostSel && !hostWr && !hostAddr;

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && !hostWr) |-> (hostRdata[PAD-1:0] == '0));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && hostWr && hostAddr) |=> (mask == $past(hostWdata[DATA_W-1:PAD])));

  p_event_latched_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((pend & $past(evtPulse)) == $past(evtPulse)));

  p_masked_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusRead |=> ((pend & $past(pend & mask)) == $past(pend & mask)));

  p_reported_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && evtPulse == '0) |=> ((pend & $past(hostRdata[DATA_W-1:PAD])) == '0));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(pend & ~mask))));

  p_lock_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & LOCK_SRC) != '0) |=> txLock);

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txLock && !(statusRead && ((hostRdata[DATA_W-1:PAD] & LOCK_SRC) != '0))) |=> txLock);
endmodule

bind irq_status_unit irq_status_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .evtPulse (evtPulse),
  .hostSel  (hostSel),
  .hostWr   (hostWr),
  .hostAddr (hostAddr),
  .hostWdata(hostWdata),
  .hostRdata(hostRdata),
  .irqOut   (irqOut),
  .txLock   (txLock),
  .pend     (dp_i.pendQ),
  .mask     (dp_i.maskQ)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtPulse = '0;
  logic       hostSel = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostAddr = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       irqOut;
  logic       txLock;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .hostSel(hostSel),
    .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .irqOut(irqOut), .txLock(txLock)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #2;
    if (hostSel && !hostWr) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (hostRdata !== e) begin
        fails++;
        $display("FAIL %s: read data %02h expected %02h", t, hostRdata, e);
      end
    end
  end

  task automatic drive(input logic [5:0] evt, input logic sel, input logic wr,
                       input logic adr, input logic [7:0] wd);
    @(negedge clk);
    evtPulse = evt; hostSel = sel; hostWr = wr; hostAddr = adr; hostWdata = wd;
    #3;
  endtask

  task automatic idle();
    drive(6'd0, 1'b0, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic pulse(input logic [5:0] evt);
    drive(evt, 1'b0, 1'b0, 1'b0, 8'd0);
  endtask

  task automatic readReg(input logic adr, input logic [7:0] exp, input string tag,
                         input logic [5:0] evt = 6'd0);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    drive(evt, 1'b1, 1'b0, adr, 8'd0);
  endtask

  task automatic writeMask(input logic [7:0] wd);
    drive(6'd0, 1'b1, 1'b1, 1'b1, wd);
  endtask

  task automatic pinCheck(input logic expIrq, input logic expLock, input string tag);
    checks++;
    if (irqOut !== expIrq || txLock !== expLock) begin
      fails++;
      $display("FAIL %s: irq/lock %b%b expected %b%b", tag, irqOut, txLock, expIrq, expLock);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    pinCheck(1'b0, 1'b0, "R1 reset pins");
    readReg(1'b0, 8'h00, "R1 status after reset");
    readReg(1'b1, 8'hFC, "R1 mask after reset");

    // masked event hidden, then unmasked
    pulse(6'b100000);
    readReg(1'b0, 8'h00, "R4 masked event hidden");
    idle();
    pinCheck(1'b0, 1'b0, "R4 masked no irq");
    writeMask(8'h00);
    idle();
    pinCheck(1'b0, 1'b0, "R7 irq one clock lag");
    idle();
    pinCheck(1'b1, 1'b0, "R7 irq raised");
    readReg(1'b0, 8'h80, "R2 status shows message end at bit7");
    idle();
    pinCheck(1'b1, 1'b0, "R7 irq still high one clock after clear");
    idle();
    pinCheck(1'b0, 1'b0, "R7 irq dropped");
    readReg(1'b0, 8'h00, "R5 read cleared reported bit");

    // mask readback
    writeMask(8'h53);
    readReg(1'b1, 8'h50, "R3 mask readback drops pad bits");

    // partial mask: only overflow masked
    writeMask(8'h20);
    pulse(6'b011000);
    readReg(1'b0, 8'h40, "R5 only unmasked pool-full reported");
    readReg(1'b0, 8'h00, "R5 reported bit cleared");
    writeMask(8'h00);
    readReg(1'b0, 8'h20, "R4 pending overflow kept while masked");
    readReg(1'b0, 8'h00, "R5 overflow cleared after unmasked read");

    // event collides with clearing read
    pulse(6'b000100);
    readReg(1'b0, 8'h10, "R6 first read of pool ready", 6'b000100);
    readReg(1'b0, 8'h10, "R6 colliding event kept bit");
    readReg(1'b0, 8'h00, "R6 later read clears");

    // underrun lock while masked
    writeMask(8'h04);
    pulse(6'b000001);
    idle();
    pinCheck(1'b0, 1'b1, "R8 lock after underrun");
    readReg(1'b0, 8'h00, "R8 masked underrun not reported");
    idle();
    pinCheck(1'b0, 1'b1, "R8 lock held across masked read");
    writeMask(8'h00);
    readReg(1'b0, 8'h04, "R8 underrun reported once unmasked");
    idle();
    pinCheck(1'b1, 1'b0, "R8 lock released after read");

    // repeat lock
    pulse(6'b000010);
    idle();
    pinCheck(1'b0, 1'b1, "R8 lock after repeat");
    readReg(1'b0, 8'h08, "R8 repeat reported at bit3");
    idle();
    pinCheck(1'b1, 1'b0, "R8 lock released after repeat read");

    // all sources at once
    pulse(6'b111111);
    readReg(1'b0, 8'hFC, "R2 all sources in bits 7..2");
    readReg(1'b0, 8'h00, "R5 all cleared");
    writeMask(8'hFF);
    readReg(1'b1, 8'hFC, "R3 full mask readback");
    idle();
    pinCheck(1'b0, 1'b0, "R7 quiet at end");

    finishRun();
  end
endmodule